// File: doc/BRIEF.md
# Cascadable Up/Down Toggle-Chain Counter

This block is a synchronous binary counter in which every flip-flop sits on the one shared clock. A toggle enable is formed in front of each bit. When the count enable is high, bit 0 flips on every edge. Any higher bit flips only when all the bits below it are 1 (counting up) or all 0 (counting down). The same serial enable chain also yields a cascade output. This output is the incoming enable ANDed with "every bit is at its terminal value", so it acts as a carry at the all-ones count while counting up and as a borrow at zero while counting down.

The top level builds one wide counter from two stages. The low stage's cascade output drives the high stage's count enable, never its clock. Both stages share the clock, reset and direction input. The top level presents the concatenated count and the high stage's cascade output, so a further instance can be chained above it the same way.

Top module: `casc_updown_counter`

## Requirements
- R1: An active-high synchronous reset clears the whole count to zero on the next clock edge and takes priority over the count enable.
- R2: While the count enable is low and reset is low, the count keeps its value across any number of clock edges.
- R3: With the enable high and the direction input at 1 (up), each edge raises the count by one, modulo 2 to the power of the total width. Bit 0 flips on every such edge, and a higher bit flips only when every lower bit is 1.
- R4: With the enable high and the direction input at 0 (down), each edge lowers the count by one. Bit 0 flips on every such edge, and a higher bit flips only when every lower bit is 0. Zero wraps to all ones in a single edge.
- R5: The cascade output is combinational. When going up, it equals the enable ANDed with "every count bit is 1". It is never high while the enable is low.
- R6: When going down, the cascade output equals the enable ANDed with "every count bit is 0".
- R7: The high stage changes only on an edge where the low stage's cascade output is high. With 4-bit stages counting up from zero, the high stage first reads 1 after the 16th enabled edge, on the same edge where the low stage wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every flip-flop in both stages |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable for the low stage |
| cnt_up | input | 1 | Direction: 1 counts up, 0 counts down |
| count | output | LO_W+HI_W | Count value; the high stage is in the upper HI_W bits |
| casc_out | output | 1 | Cascade output for chaining: carry going up, borrow going down |

## Verification
The bench keeps the default of two 4-bit stages, so the total count is 8 bits wide. With this width, the full 256-state wrap in both directions is reached within a few hundred edges. The stage boundary at the low nibble's 15-to-0 rollover falls on the 16th edge, which the bench checks exactly. Narrow stages also mean that every carry and borrow from the low to the high stage is crossed many times during the long up and down runs.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/tgl_enable_chain.sv
module tgl_enable_chain
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         en,
    input  cnt_dir_e     dir,
    output logic [W-1:0] tgl,
    output logic         term
);
    // e[k] is the enable arriving at bit k; one 2-input AND per stage
    logic [W:0] e;
    assign e[0] = en;

    for (genvar k = 0; k < W; k++) begin : g_link
        logic at_term;
        assign at_term  = (dir == DIR_UP) ? q[k] : ~q[k];
        assign e[k+1]   = e[k] & at_term;
        assign tgl[k]   = e[k];
    end

    assign term = e[W];
endmodule

// File: rtl/tgl_counter_stage.sv
module tgl_counter_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  cnt_dir_e     dir,
    output logic [W-1:0] q,
    output logic         tc
);
    localparam logic [W-1:0] STEP = W'(1);

    logic [W-1:0] tgl;

    tgl_enable_chain #(.W(W)) u_chain (
        .q    (q),
        .en   (en),
        .dir  (dir),
        .tgl  (tgl),
        .term (tc)
    );

    for (genvar k = 0; k < W; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[k] <= 1'b0;
            end else if (tgl[k]) begin
                q[k] <= ~q[k];
            end
        end
    end

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir == DIR_UP) |=> q == $past(q) + STEP);

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && dir == DIR_DOWN) |=> q == $past(q) - STEP);

    // R3
    bit0_flip_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> q[0] != $past(q[0]));

    // R5
    tc_gated_chk: assert property (@(posedge clk) disable iff (rst)
        tc |-> en);

    // R6
    tc_down_chk: assert property (@(posedge clk) disable iff (rst)
        (tc && dir == DIR_DOWN) |=> q == '1);
endmodule

// File: rtl/casc_updown_counter.sv
module casc_updown_counter
    import cnt_pkg::*;
#(
    parameter int LO_W = 4,
    parameter int HI_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cnt_en,
    input  logic                 cnt_up,
    output logic [LO_W+HI_W-1:0] count,
    output logic                 casc_out
);
    cnt_dir_e         dir;
    logic [LO_W-1:0]  lo_q;
    logic [HI_W-1:0]  hi_q;
    logic             lo_tc;

    assign dir = cnt_dir_e'(cnt_up);

    tgl_counter_stage #(.W(LO_W)) u_lo (
        .clk (clk),
        .rst (rst),
        .en  (cnt_en),
        .dir (dir),
        .q   (lo_q),
        .tc  (lo_tc)
    );

    // low stage terminal count feeds the high stage enable, same clock
    tgl_counter_stage #(.W(HI_W)) u_hi (
        .clk (clk),
        .rst (rst),
        .en  (lo_tc),
        .dir (dir),
        .q   (hi_q),
        .tc  (casc_out)
    );

    assign count = {hi_q, lo_q};

    logic was_rst;
    always_ff @(posedge clk) begin
        was_rst <= rst;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        was_rst |-> count == '0);

    // R7
    hi_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !lo_tc |=> $stable(hi_q));

    // R7
    hi_step_chk: assert property (@(posedge clk) disable iff (rst)
        lo_tc |=> hi_q != $past(hi_q));

    // R5
    casc_up_chk: assert property (@(posedge clk) disable iff (rst)
        (casc_out && cnt_up) |-> count == '1);
endmodule

// File: tb/casc_updown_counter_test.sv
module casc_updown_counter_test;
    localparam int CW = 8;

    typedef struct packed {
        logic          rst;
        logic          en;
        logic          up;
        logic          exp_co;
        logic [CW-1:0] exp_cnt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{rst:1'b1, en:1'b1, up:1'b1, exp_co:1'b0, exp_cnt:8'h00},
        '{rst:1'b0, en:1'b1, up:1'b1, exp_co:1'b0, exp_cnt:8'h01},
        '{rst:1'b0, en:1'b0, up:1'b1, exp_co:1'b0, exp_cnt:8'h01},
        '{rst:1'b0, en:1'b1, up:1'b0, exp_co:1'b0, exp_cnt:8'h00},
        '{rst:1'b0, en:1'b1, up:1'b0, exp_co:1'b1, exp_cnt:8'hFF},
        '{rst:1'b0, en:1'b1, up:1'b1, exp_co:1'b1, exp_cnt:8'h00},
        '{rst:1'b0, en:1'b0, up:1'b0, exp_co:1'b0, exp_cnt:8'h00},
        '{rst:1'b0, en:1'b1, up:1'b0, exp_co:1'b1, exp_cnt:8'hFF},
        '{rst:1'b0, en:1'b1, up:1'b0, exp_co:1'b0, exp_cnt:8'hFE},
        '{rst:1'b0, en:1'b1, up:1'b1, exp_co:1'b0, exp_cnt:8'hFF},
        '{rst:1'b0, en:1'b0, up:1'b1, exp_co:1'b0, exp_cnt:8'hFF},
        '{rst:1'b1, en:1'b1, up:1'b1, exp_co:1'b1, exp_cnt:8'h00},
        '{rst:1'b0, en:1'b1, up:1'b1, exp_co:1'b0, exp_cnt:8'h01}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cnt_en = 1'b0;
    logic          cnt_up = 1'b1;
    logic [CW-1:0] count;
    logic          casc_out;

    int  applied = 0;
    int  miss = 0;
    bit  done = 1'b0;

    casc_updown_counter uut (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .cnt_up   (cnt_up),
        .count    (count),
        .casc_out (casc_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        applied++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at negedge, check combinational output, then count after the edge
    task automatic step(input logic r, input logic e, input logic u,
                        input logic eco, input int ecnt, input string req);
        @(negedge clk);
        rst = r; cnt_en = e; cnt_up = u;
        #1;
        check({req, " casc_out"}, int'(casc_out), int'(eco));
        @(posedge clk);
        #1;
        check({req, " count"}, int'(count), ecnt);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", applied, miss);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        applied++;
        miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int model;
        // R1 reset state
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset state", int'(count), 0);

        // table walk: R1..R6
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].rst, VECS[i].en, VECS[i].up,
                 VECS[i].exp_co, int'(VECS[i].exp_cnt), "R1-vec");
        end

        // R7: stage boundary on the 16th edge
        step(1'b1, 1'b0, 1'b1, 1'b0, 0, "R1 reset");
        for (int i = 1; i <= 15; i++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, i, "R7 low fill");
        end
        step(1'b0, 1'b1, 1'b1, 1'b0, 16, "R7 sixteenth edge");
        // borrow back across the boundary
        step(1'b0, 1'b1, 1'b0, 1'b0, 15, "R7 borrow");

        // R2: long hold
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 1'b0, i[0], 1'b0, 15, "R2 hold");
        end

        // R3/R5: full up run with model
        model = 15;
        for (int i = 0; i < 300; i++) begin
            step(1'b0, 1'b1, 1'b1, (model == 255) ? 1'b1 : 1'b0,
                 (model + 1) % 256, "R3 R5 up run");
            model = (model + 1) % 256;
        end

        // R4/R6: full down run with model
        for (int i = 0; i < 300; i++) begin
            step(1'b0, 1'b1, 1'b0, (model == 0) ? 1'b1 : 1'b0,
                 (model + 255) % 256, "R4 R6 down run");
            model = (model + 255) % 256;
        end

        // R5 R6: enable low gates the cascade output at zero and at all ones
        step(1'b1, 1'b0, 1'b0, 1'b0, 0, "R1 reset");
        step(1'b0, 1'b0, 1'b0, 1'b0, 0, "R6 gated at zero");
        step(1'b0, 1'b1, 1'b0, 1'b1, 255, "R4 wrap to all ones");
        step(1'b0, 1'b0, 1'b1, 1'b0, 255, "R5 gated at all ones");

        finish_run();
    end
endmodule